// File: doc/BRIEF.md
# Inter-Processor Message Mailbox

This block lets several processors exchange 32-bit words through a set of small hardware queues behind one register bus. A sender writes a word to a queue's message register; the receiver reads the same register to take the oldest word out. Each queue also shows, as separate read-only registers, how many words it holds and whether it can accept another.

Every processor (a "user") owns an interrupt status register and an interrupt enable register. Each queue contributes two events to every user: one when a word is pushed (new message) and one when a word is taken out (room available). A user's interrupt line is raised while any of its pending events is also enabled. Software acknowledges an event by writing 1 to its status bit. A build-time parameter selects one of two user-register layouts. The second layout adds a per-user enable-clear register, and in that layout the enable register sets bits rather than overwriting them.

Top module: `ipc_mailbox`

## Requirements
- R1: A read at offset 0x000 returns the revision: major number (parameter, default 2) in bits [7:4], minor number (default 1) in bits [3:0], all other bits zero.
- R2: Queue m's message register is at 0x040 + 4*m. A write appends the 32-bit word, and a read returns the oldest stored word and removes it, so words come out in the order they went in. A queue holds DEPTH words (default 4).
- R3: Queue m's full flag is at 0x080 + 4*m and reads 1 when the queue holds DEPTH words, otherwise 0. A write to a full queue is discarded and leaves the contents unchanged.
- R4: A read of an empty queue's message register returns zero and leaves the queue empty.
- R5: Queue m's word count is at 0x0C0 + 4*m and reads the number of words stored (0 means empty).
- R6: An accepted write to queue m sets bit 2*m (new message) in the status register of every user.
- R7: A read that removes a word from queue m sets bit 2*m+1 (room available) in the status register of every user.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A hardware set in the same cycle as a clear wins.
- R9: irq_out[u] is high exactly when some bit is set in both user u's status and enable registers. It follows register updates in the same cycle, with no added latency.
- R10: Base layout (ALT_LAYOUT=0): user u's status is at 0x100 + 8*u and its enable at 0x104 + 8*u. A write to the enable register replaces it.
- R11: Alternate layout (ALT_LAYOUT=1): user u's status is at 0x104 + 16*u, its enable at 0x108 + 16*u (a write sets the 1 bits) and its enable-clear at 0x10C + 16*u (a write clears the 1 bits; it reads 0).
- R12: Reset (rst_n low at a clock edge) empties all queues and clears all status and enable bits. Read data appears on bus_rdata one cycle after a read strobe and holds until the next read.
- R13: Unmapped or misaligned offsets read zero, and writes to them change no queue, status or enable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (9) | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_out | output | NUM_U (2) | Interrupt line per user |

## Verification
The bench builds two copies side by side, both with four queues, two users and four-entry queues: one in the base layout and one in the alternate layout. With four entries, filling a queue and overflowing it takes only a few accesses. The eight event bits cover every queue's new-message and room-available positions. Two users show that one push raises the same event for both users while each user masks it separately. Running both layouts shows the overwrite and set/clear enable semantics, and the different status offsets, against one shared reference model.

// File: rtl/ipc_mbox_pkg.sv
// Shared types for the inter-processor mailbox.
// Assumes a 32-bit register bus and at most 256 queues or users.
package ipc_mbox_pkg;
    localparam int WORD_W = 32;
    localparam int SLOT_W = 8;

    // Kind of register an address selects
    typedef enum logic [2:0] {
        RK_NONE,
        RK_REV,
        RK_MSG,
        RK_FULL,
        RK_CNT,
        RK_STAT,
        RK_EN,
        RK_ENCLR
    } reg_kind_e;

    // Decoded access: register kind plus queue or user index
    typedef struct packed {
        reg_kind_e          kind;
        logic [SLOT_W-1:0]  slot;
    } reg_sel_t;
endpackage

// File: rtl/mbox_fifo.sv
// One message queue: DEPTH words, push and pop requests qualified here.
// Assumes DEPTH >= 2 and never a push and a pop in the same cycle from
// the single bus (both are still handled if they arrive together).
module mbox_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic [WIDTH-1:0] wdata,
    output logic             push_ok,
    output logic             pop_ok,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    // Next position with wrap at DEPTH
    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push_req && !full;
    assign pop_ok  = pop_req && !empty;
    assign head    = mem[rd_ptr];

    // Store pushed word
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // Advance pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push_ok) wr_ptr <= step(wr_ptr);
            if (pop_ok)  rd_ptr <= step(rd_ptr);
        end
    end

    // Track occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/mbox_user_irq.sv
// Per-user interrupt status and enable with a combined interrupt line.
// Status: hardware set, write-1-to-clear, set wins. Enable: overwrite when
// SET_MODE=0, write-1-to-set when SET_MODE=1; separate write-1-to-clear.
module mbox_user_irq #(
    parameter int NEV      = 8,
    parameter bit SET_MODE = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] hw_set,
    input  logic           stat_clr_we,
    input  logic           en_we,
    input  logic           en_clr_we,
    input  logic [NEV-1:0] wbits,
    output logic [NEV-1:0] status,
    output logic [NEV-1:0] enable,
    output logic           irq
);
    logic [NEV-1:0] clr_mask;

    assign clr_mask = stat_clr_we ? wbits : '0;
    assign irq      = |(status & enable);

    // Pending events: clear by software, set by hardware with priority
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_mask) | hw_set;
    end

    // Event enables
    always_ff @(posedge clk) begin
        if (!rst_n)         enable <= '0;
        else if (en_we)     enable <= SET_MODE ? (enable | wbits) : wbits;
        else if (en_clr_we) enable <= enable & ~wbits;
    end
endmodule

// File: rtl/mbox_addr_decode.sv
// Maps a byte offset to a register kind and a queue or user index.
// Assumes NUM_Q <= 16 so queue regions stay inside their 64-byte windows.
module mbox_addr_decode
    import ipc_mbox_pkg::*;
#(
    parameter int NUM_Q      = 4,
    parameter int NUM_U      = 2,
    parameter bit ALT_LAYOUT = 1'b0,
    parameter int ADDR_W     = 9
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam int Q_SPAN    = 4 * NUM_Q;
    localparam int MSG_BASE  = 'h040;
    localparam int FULL_BASE = 'h080;
    localparam int CNT_BASE  = 'h0C0;

    reg_sel_t q_sel;
    reg_sel_t u_sel;

    // Queue and revision region
    always_comb begin
        int a;
        a = int'(addr);
        q_sel = '{kind: RK_NONE, slot: '0};
        if (a == 0) begin
            q_sel.kind = RK_REV;
        end else if (a >= MSG_BASE && a < MSG_BASE + Q_SPAN) begin
            q_sel = '{kind: RK_MSG, slot: SLOT_W'((a - MSG_BASE) >> 2)};
        end else if (a >= FULL_BASE && a < FULL_BASE + Q_SPAN) begin
            q_sel = '{kind: RK_FULL, slot: SLOT_W'((a - FULL_BASE) >> 2)};
        end else if (a >= CNT_BASE && a < CNT_BASE + Q_SPAN) begin
            q_sel = '{kind: RK_CNT, slot: SLOT_W'((a - CNT_BASE) >> 2)};
        end
    end

    // User region, variant picked by layout
    if (ALT_LAYOUT) begin : g_alt
        localparam int U_BASE = 'h104;
        always_comb begin
            int off;
            off = int'(addr) - U_BASE;
            u_sel = '{kind: RK_NONE, slot: '0};
            if (off >= 0 && (off >> 4) < NUM_U) begin
                u_sel.slot = SLOT_W'(off >> 4);
                case (off & 15)
                    0:       u_sel.kind = RK_STAT;
                    4:       u_sel.kind = RK_EN;
                    8:       u_sel.kind = RK_ENCLR;
                    default: u_sel.kind = RK_NONE;
                endcase
            end
        end
    end else begin : g_base
        localparam int U_BASE = 'h100;
        always_comb begin
            int off;
            off = int'(addr) - U_BASE;
            u_sel = '{kind: RK_NONE, slot: '0};
            if (off >= 0 && (off >> 3) < NUM_U) begin
                u_sel.slot = SLOT_W'(off >> 3);
                case (off & 7)
                    0:       u_sel.kind = RK_STAT;
                    4:       u_sel.kind = RK_EN;
                    default: u_sel.kind = RK_NONE;
                endcase
            end
        end
    end

    // Combine regions, reject misaligned offsets
    always_comb begin
        if (addr[1:0] != 2'b00)       sel = '{kind: RK_NONE, slot: '0};
        else if (q_sel.kind != RK_NONE) sel = q_sel;
        else                            sel = u_sel;
    end
endmodule

// File: rtl/ipc_mailbox.sv
// Inter-processor mailbox top: NUM_Q message queues, NUM_U users with
// per-user interrupt status/enable, registered read data.
// Assumes one bus access (read or write) per cycle.
module ipc_mailbox
    import ipc_mbox_pkg::*;
#(
    parameter int NUM_Q      = 4,
    parameter int NUM_U      = 2,
    parameter int DEPTH      = 4,
    parameter bit ALT_LAYOUT = 1'b0,
    parameter int ADDR_W     = 9,
    parameter int REV_MAJOR  = 2,
    parameter int REV_MINOR  = 1,
    localparam int NEV       = 2 * NUM_Q,
    localparam int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [NUM_U-1:0]  irq_out
);
    reg_sel_t              sel;
    logic [NUM_Q-1:0]      q_push;
    logic [NUM_Q-1:0]      q_pop;
    logic [NUM_Q-1:0]      q_full;
    logic [NUM_Q-1:0]      q_empty;
    logic [WORD_W-1:0]     q_head [NUM_Q];
    logic [NUM_Q*CNT_W-1:0] q_count_flat;
    logic [NEV-1:0]        events;
    logic [NEV-1:0]        u_status [NUM_U];
    logic [NEV-1:0]        u_enable [NUM_U];
    logic [NUM_U*NEV-1:0]  status_flat;
    logic [NUM_U*NEV-1:0]  enable_flat;
    logic [WORD_W-1:0]     rd_next;

    mbox_addr_decode #(
        .NUM_Q(NUM_Q), .NUM_U(NUM_U), .ALT_LAYOUT(ALT_LAYOUT), .ADDR_W(ADDR_W)
    ) u_dec (
        .addr(bus_addr),
        .sel (sel)
    );

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        logic hit;
        assign hit = (sel.kind == RK_MSG) && (sel.slot == SLOT_W'(q));
        mbox_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .push_req(bus_wr && hit),
            .pop_req (bus_rd && hit),
            .wdata   (bus_wdata),
            .push_ok (q_push[q]),
            .pop_ok  (q_pop[q]),
            .head    (q_head[q]),
            .count   (q_count_flat[q*CNT_W +: CNT_W]),
            .full    (q_full[q]),
            .empty   (q_empty[q])
        );
        assign events[2*q]     = q_push[q];
        assign events[2*q + 1] = q_pop[q];
    end

    for (genvar u = 0; u < NUM_U; u++) begin : g_u
        logic mine;
        assign mine = bus_wr && (sel.slot == SLOT_W'(u));
        mbox_user_irq #(.NEV(NEV), .SET_MODE(ALT_LAYOUT)) u_irq (
            .clk        (clk),
            .rst_n      (rst_n),
            .hw_set     (events),
            .stat_clr_we(mine && sel.kind == RK_STAT),
            .en_we      (mine && sel.kind == RK_EN),
            .en_clr_we  (mine && sel.kind == RK_ENCLR),
            .wbits      (bus_wdata[NEV-1:0]),
            .status     (u_status[u]),
            .enable     (u_enable[u]),
            .irq        (irq_out[u])
        );
        assign status_flat[u*NEV +: NEV] = u_status[u];
        assign enable_flat[u*NEV +: NEV] = u_enable[u];
    end

    // Read data selection for the current access
    always_comb begin
        rd_next = '0;
        case (sel.kind)
            RK_REV: rd_next = WORD_W'({4'(REV_MAJOR), 4'(REV_MINOR)});
            RK_MSG, RK_FULL, RK_CNT: begin
                for (int q = 0; q < NUM_Q; q++) begin
                    if (sel.slot == SLOT_W'(q)) begin
                        if (sel.kind == RK_MSG)
                            rd_next = q_empty[q] ? '0 : q_head[q];
                        else if (sel.kind == RK_FULL)
                            rd_next = WORD_W'(q_full[q]);
                        else
                            rd_next = WORD_W'(q_count_flat[q*CNT_W +: CNT_W]);
                    end
                end
            end
            RK_STAT, RK_EN: begin
                for (int u = 0; u < NUM_U; u++) begin
                    if (sel.slot == SLOT_W'(u))
                        rd_next = WORD_W'((sel.kind == RK_STAT) ? u_status[u] : u_enable[u]);
                end
            end
            default: rd_next = '0;
        endcase
    end

    // Register read data on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end
endmodule

// File: rtl/ipc_mailbox_checker.sv
// Temporal checks for ipc_mailbox, attached with bind below.
module ipc_mailbox_checker #(
    parameter int NUM_Q = 4,
    parameter int NUM_U = 2,
    parameter int DEPTH = 4,
    localparam int NEV   = 2 * NUM_Q,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_Q*CNT_W-1:0] q_count,
    input logic [NUM_Q-1:0]       q_push,
    input logic [NUM_Q-1:0]       q_pop,
    input logic [NUM_U*NEV-1:0]   status,
    input logic [NUM_U*NEV-1:0]   enable,
    input logic [NUM_U-1:0]       irq_out
);
    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            q_count[q*CNT_W +: CNT_W] <= CNT_W'(DEPTH));

        a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
            (q_push[q] && !q_pop[q]) |=>
            (q_count[q*CNT_W +: CNT_W] == $past(q_count[q*CNT_W +: CNT_W]) + 1'b1));

        for (genvar u = 0; u < NUM_U; u++) begin : g_u
            a_r6_newmsg_set: assert property (@(posedge clk) disable iff (!rst_n)
                q_push[q] |=> status[u*NEV + 2*q]);

            a_r7_room_set: assert property (@(posedge clk) disable iff (!rst_n)
                q_pop[q] |=> status[u*NEV + 2*q + 1]);
        end
    end

    for (genvar u = 0; u < NUM_U; u++) begin : g_irq
        a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (enable[u*NEV +: NEV] == '0) |-> !irq_out[u]);

        a_r9_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out[u] |-> (status[u*NEV +: NEV] != '0));
    end
endmodule

bind ipc_mailbox ipc_mailbox_checker #(
    .NUM_Q(NUM_Q), .NUM_U(NUM_U), .DEPTH(DEPTH)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .q_count(q_count_flat),
    .q_push (q_push),
    .q_pop  (q_pop),
    .status (status_flat),
    .enable (enable_flat),
    .irq_out(irq_out)
);

// File: tb/ipc_mailbox_test.sv
`timescale 1ns/1ps
// Bench: base-layout and alternate-layout mailboxes against one model.
module ipc_mailbox_test;
    localparam int NQ = 4;
    localparam int NU = 2;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr0 = 1'b0, rd0 = 1'b0, wr1 = 1'b0, rd1 = 1'b0;
    logic [8:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata0, rdata1;
    logic [1:0]  irq0, irq1;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] mq [2][NQ][$];
    logic [7:0]  st [2][NU];
    logic [7:0]  en [2][NU];

    always #4 clk = ~clk;

    ipc_mailbox #(.ALT_LAYOUT(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr0), .bus_rd(rd0), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata0), .irq_out(irq0)
    );

    ipc_mailbox #(.ALT_LAYOUT(1'b1)) uut_alt (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr1), .bus_rd(rd1), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata1), .irq_out(irq1)
    );

    function automatic int st_addr(int d, int u);
        return (d == 0) ? ('h100 + 8 * u) : ('h104 + 16 * u);
    endfunction
    function automatic int en_addr(int d, int u);
        return (d == 0) ? ('h104 + 8 * u) : ('h108 + 16 * u);
    endfunction
    function automatic logic [1:0] exp_irq(int d);
        logic [1:0] r;
        for (int u = 0; u < NU; u++) r[u] = |(st[d][u] & en[d][u]);
        return r;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(int d, int a, logic [31:0] v);
        @(negedge clk);
        addr = 9'(a); wdata = v;
        if (d == 0) wr0 = 1'b1; else wr1 = 1'b1;
        @(negedge clk);
        wr0 = 1'b0; wr1 = 1'b0;
    endtask

    task automatic bus_read(int d, int a, output logic [31:0] v);
        @(negedge clk);
        addr = 9'(a);
        if (d == 0) rd0 = 1'b1; else rd1 = 1'b1;
        @(negedge clk);
        rd0 = 1'b0; rd1 = 1'b0;
        v = (d == 0) ? rdata0 : rdata1;
    endtask

    task automatic chk_irq(int d);
        chk("R9 irq", 32'((d == 0) ? irq0 : irq1), 32'(exp_irq(d)));
    endtask

    task automatic m_push(int d, int q, logic [31:0] v);
        bus_write(d, 'h40 + 4 * q, v);
        if (mq[d][q].size() < DEPTH) begin
            mq[d][q].push_back(v);
            for (int u = 0; u < NU; u++) st[d][u][2*q] = 1'b1;
        end
        chk_irq(d);
    endtask

    task automatic m_pop(int d, int q, string tag);
        logic [31:0] got, exp;
        bus_read(d, 'h40 + 4 * q, got);
        exp = '0;
        if (mq[d][q].size() > 0) begin
            exp = mq[d][q].pop_front();
            for (int u = 0; u < NU; u++) st[d][u][2*q+1] = 1'b1;
        end
        chk(tag, got, exp);
        chk_irq(d);
    endtask

    task automatic m_count(int d, int q);
        logic [31:0] got;
        bus_read(d, 'hC0 + 4 * q, got);
        chk("R5 count", got, 32'(mq[d][q].size()));
    endtask

    task automatic m_full(int d, int q);
        logic [31:0] got;
        bus_read(d, 'h80 + 4 * q, got);
        chk("R3 full flag", got, 32'(mq[d][q].size() == DEPTH));
    endtask

    task automatic m_stat(int d, int u, string tag);
        logic [31:0] got;
        bus_read(d, st_addr(d, u), got);
        chk(tag, got, 32'(st[d][u]));
    endtask

    task automatic m_en(int d, int u, string tag);
        logic [31:0] got;
        bus_read(d, en_addr(d, u), got);
        chk(tag, got, 32'(en[d][u]));
    endtask

    task automatic m_clr_stat(int d, int u, logic [7:0] v);
        bus_write(d, st_addr(d, u), 32'(v));
        st[d][u] = st[d][u] & ~v;
        chk_irq(d);
    endtask

    task automatic m_set_en(int d, int u, logic [7:0] v);
        bus_write(d, en_addr(d, u), 32'(v));
        en[d][u] = (d == 0) ? v : (en[d][u] | v);
        chk_irq(d);
    endtask

    task automatic m_clr_en(int d, int u, logic [7:0] v);
        bus_write(d, 'h10C + 16 * u, 32'(v));
        en[d][u] = en[d][u] & ~v;
        chk_irq(d);
    endtask

    initial begin
        logic [31:0] got;
        void'($urandom(32'd20240611));
        for (int d = 0; d < 2; d++)
            for (int u = 0; u < NU; u++) begin st[d][u] = '0; en[d][u] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state, R1 revision
        for (int d = 0; d < 2; d++) begin
            chk("R12 irq after reset", 32'((d == 0) ? irq0 : irq1), 32'h0);
            bus_read(d, 'h000, got);
            chk("R1 revision", got, 32'h21);
            m_count(d, 3);
            m_stat(d, 1, "R12 status after reset");
            m_en(d, 0, "R12 enable after reset");
        end

        // R4 empty read
        m_pop(0, 0, "R4 empty read");
        m_count(0, 0);

        // R2 ordering, R6 new-message bit
        m_push(0, 1, 32'hA1A1_0001);
        m_push(0, 1, 32'hA1A1_0002);
        m_push(0, 1, 32'hA1A1_0003);
        m_stat(0, 0, "R6 newmsg bit user0");
        m_stat(0, 1, "R6 newmsg bit user1");
        m_count(0, 1);
        m_pop(0, 1, "R2 order first");
        m_stat(0, 1, "R7 room bit");
        m_pop(0, 1, "R2 order second");
        m_pop(0, 1, "R2 order third");

        // R3 overflow on the alternate copy
        for (int i = 0; i < 5; i++) m_push(1, 2, 32'hC0DE_0000 + 32'(i));
        m_count(1, 2);
        m_full(1, 2);
        m_pop(1, 2, "R3 overflow dropped, oldest");
        m_full(1, 2);
        for (int i = 0; i < 3; i++) m_pop(1, 2, "R3 remaining order");

        // R8 write-0 no effect, write-1 clears
        m_clr_stat(0, 0, 8'h00);
        m_stat(0, 0, "R8 write zero keeps");
        m_clr_stat(0, 0, 8'h04);
        m_stat(0, 0, "R8 write one clears");

        // R9 / R10 base enable overwrite
        m_set_en(0, 1, 8'h08);
        chk("R9 irq asserted", 32'(irq0), 32'(exp_irq(0)));
        m_set_en(0, 1, 8'h00);
        m_en(0, 1, "R10 overwrite enable");

        // R11 alternate set and clear
        m_set_en(1, 0, 8'h10);
        m_set_en(1, 0, 8'h20);
        m_en(1, 0, "R11 enable set accumulates");
        m_clr_en(1, 0, 8'h10);
        m_en(1, 0, "R11 enable clear");
        bus_read(1, 'h10C, got);
        chk("R11 clear reg reads zero", got, 32'h0);

        // R13 unmapped access
        bus_read(0, 'h020, got);
        chk("R13 unmapped read", got, 32'h0);
        bus_read(0, 'h042, got);
        chk("R13 misaligned read", got, 32'h0);
        bus_write(0, 'h110, 32'hFFFF_FFFF);
        m_stat(0, 0, "R13 unmapped write no effect");
        m_en(0, 0, "R13 unmapped write enable kept");
        m_count(0, 0);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int d, q, u, op;
            d = int'($urandom % 2);
            q = int'($urandom % NQ);
            u = int'($urandom % NU);
            op = int'($urandom % 9);
            case (op)
                0, 1, 2: m_push(d, q, $urandom);
                3, 4:    m_pop(d, q, "R2 random pop");
                5:       begin m_count(d, q); m_full(d, q); end
                6:       m_clr_stat(d, u, 8'($urandom));
                7:       if (d == 1 && ($urandom % 2) == 1) m_clr_en(d, u, 8'($urandom));
                         else m_set_en(d, u, 8'($urandom));
                default: begin m_stat(d, u, "R6 R7 random status"); m_en(d, u, "R10 R11 random enable"); end
            endcase
        end

        // R12 reset mid-run
        m_push(0, 0, 32'h1234_5678);
        m_set_en(0, 0, 8'hFF);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int d = 0; d < 2; d++) begin
            for (int q = 0; q < NQ; q++) mq[d][q].delete();
            for (int uu = 0; uu < NU; uu++) begin st[d][uu] = '0; en[d][uu] = '0; end
        end
        chk("R12 irq cleared", 32'(irq0), 32'h0);
        m_count(0, 0);
        m_en(0, 0, "R12 enable cleared");
        m_stat(0, 0, "R12 status cleared");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (30000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule